// File: doc/BRIEF.md
# Master-Clock Ratio Detector with Drift Resync and Startup Mute

This block watches the serial audio port of a converter that runs as a clock slave. Running on the master clock, it measures how many master-clock cycles fit between rising edges of the incoming frame clock. It then snaps that count to one of six supported master-to-sample-rate ratios and reports the result as a small code with a locked flag. Nothing in the block assumes a fixed phase between the master clock and the frame clock.

Once locked, the block keeps its own frame timing, derived from the master clock and the detected ratio. At each frame edge it counts how many bit-clock rising edges separate the real frame edge from the internal frame boundary. When that distance grows beyond a window of bit clocks, it raises a one-cycle resync pulse and realigns its internal timing to the edge. The downstream serialiser may drop or repeat a sample at that point.

After reset, a mute output keeps the serial data at zero for a fixed startup interval. The interval is counted on the master clock alone, so a missing or idle frame clock cannot shorten or extend it. A digital reset input stands in for power-good detection, and the internal logic leaves reset a few master-clock cycles after that input is released.

Top module: `mclk_ratio_monitor`

## Requirements
- R1: While `rst_ni` is low, `mute_o` is 1, `locked_o` is 0, `resync_o` is 0 and `ratio_code_o` is 0.
- R2: `mute_o` stays 1 for RELEASE_DLY + MUTE_FRAMES*MUTE_RATIO master-clock cycles after `rst_ni` rises (4 + 32*256 by default), whatever the frame clock does. It then falls to 0 and stays 0 until the next reset.
- R3: A frame period P, in master-clock cycles, matches ratio r when |P - r| <= floor(r/50). The ratios and their codes are 128→0, 192→1, 256→2, 384→3, 512→4 and 768→5.
- R4: The first frame-clock rising edge after reset only starts a measurement. `locked_o` rises only after two consecutive measurements match the same ratio, so it rises at the third edge at the earliest.
- R5: `ratio_code_o` changes only after two consecutive measurements match the new ratio. A single measurement that matches a different ratio leaves both the code and `locked_o` unchanged.
- R6: A measurement that matches no ratio clears `locked_o` at that frame edge. `ratio_code_o` keeps its last value.
- R7: If no frame-clock rising edge arrives for 1536 master-clock cycles (twice the largest ratio), `locked_o` falls to 0.
- R8: While locked, at each matching frame edge the block counts the bit-clock rising edges between its internal frame boundary and the real edge. This count is taken modulo a 64-bit-clock frame. If the distance is more than 8 bit clocks, `resync_o` pulses and the internal boundary is moved to that edge.
- R9: `resync_o` is never raised when the frame period equals the locked ratio exactly, and never while `locked_o` is 0.
- R10: Each `resync_o` pulse lasts exactly one master-clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk_i | input | 1 | Master clock; all logic runs on it |
| rst_ni | input | 1 | Active-low asynchronous reset standing in for power-good |
| frame_clk_i | input | 1 | Incoming frame (left/right) clock, asynchronous to mclk_i |
| bit_clk_i | input | 1 | Incoming bit clock, asynchronous to mclk_i |
| ratio_code_o | output | 3 | Detected ratio code, 0..5 |
| locked_o | output | 1 | High while a valid ratio is confirmed |
| resync_o | output | 1 | One-cycle pulse when phase drift forces realignment |
| mute_o | output | 1 | High while the serial data output must be held at zero |

## Verification
A wrong lock-filter state shows up one frame edge early or late on `locked_o` or `ratio_code_o`. The bench therefore checks those outputs at frame boundaries, right after the edge where the change is due. A faulty phase counter shows up as resync pulses on an exactly periodic frame clock, or as silence under steady drift, within a handful of frames. A bad startup counter moves the fall of `mute_o` away from its fixed master-clock count, and the bench detects this within a few cycles of the expected point.

// File: rtl/crd_pkg.sv
package crd_pkg;
   localparam int unsigned NUM_RATIOS = 6;
   localparam int unsigned CODE_W     = 3;

   typedef logic [CODE_W-1:0] ratio_code_t;

   // Ratio for a code: even codes are powers of two times the base,
   // odd codes are one and a half times the even code below them.
   function automatic int unsigned ratio_of(input int unsigned base, input ratio_code_t code);
      int unsigned r;
      r = base << (code >> 1);
      if (code[0]) r = r + (r >> 1);
      return r;
   endfunction
endpackage

// File: rtl/crd_sync.sv
module crd_sync #(
   parameter int unsigned STAGES = 2,
   parameter int unsigned W      = 1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] stg_q [STAGES];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
      end else begin
         stg_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/crd_startup.sv
module crd_startup #(
   parameter int unsigned RELEASE_DLY = 4,
   parameter int unsigned MUTE_CYCLES = 8192
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic int_rst_no,
   output logic mute_o
);
   localparam int unsigned MW = $clog2(MUTE_CYCLES + 1);

   if (RELEASE_DLY == 1) begin : g_rel_single
      logic rel_q;
      always_ff @(posedge clk_i or negedge rst_ni)
         if (!rst_ni) rel_q <= 1'b0;
         else         rel_q <= 1'b1;
      assign int_rst_no = rel_q;
   end else begin : g_rel_chain
      logic [RELEASE_DLY-1:0] rel_q;
      always_ff @(posedge clk_i or negedge rst_ni)
         if (!rst_ni) rel_q <= '0;
         else         rel_q <= {rel_q[RELEASE_DLY-2:0], 1'b1};
      assign int_rst_no = rel_q[RELEASE_DLY-1];
   end

   logic [MW-1:0] mute_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         mute_q <= '0;
      else if (int_rst_no && (mute_q != MW'(MUTE_CYCLES)))
         mute_q <= mute_q + 1'b1;
   end

   assign mute_o = (mute_q != MW'(MUTE_CYCLES));
endmodule

// File: rtl/crd_classify.sv
module crd_classify
   import crd_pkg::*;
#(
   parameter int unsigned BASE_RATIO = 128,
   parameter int unsigned TOL_DIV    = 50,
   parameter int unsigned PERIOD_SAT = 1536
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        edge_i,
   output logic        hit_o,
   output logic        align_o,
   output logic        locked_o,
   output ratio_code_t code_o
);
   localparam int unsigned PW = $clog2(PERIOD_SAT + 1);

   logic [PW-1:0]         per_q;
   logic                  seen_q;
   logic [NUM_RATIOS-1:0] hit_vec;
   ratio_code_t           mcode;

   // One window comparator per supported ratio.
   for (genvar k = 0; k < NUM_RATIOS; k++) begin : g_win
      localparam int unsigned R   = ratio_of(BASE_RATIO, CODE_W'(k));
      localparam int unsigned TOL = R / TOL_DIV;
      assign hit_vec[k] = (per_q >= PW'(R - TOL)) && (per_q <= PW'(R + TOL));
   end

   always_comb begin
      mcode = '0;
      for (int k = 0; k < NUM_RATIOS; k++)
         if (hit_vec[k]) mcode = CODE_W'(k);
   end

   logic sat, meas, mhit;
   assign sat  = (per_q == PW'(PERIOD_SAT)) && !edge_i;
   assign meas = (edge_i && seen_q) || sat;
   assign mhit = edge_i && seen_q && (|hit_vec);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         per_q  <= '0;
         seen_q <= 1'b0;
      end else if (edge_i) begin
         per_q  <= PW'(1);
         seen_q <= 1'b1;
      end else if (sat) begin
         per_q  <= '0;
         seen_q <= 1'b0;
      end else if (seen_q) begin
         per_q  <= per_q + 1'b1;
      end
   end

   logic        pv_q, lk_q;
   ratio_code_t pc_q, cur_q;
   logic        confirm;

   assign confirm = mhit && pv_q && (pc_q == mcode);
   assign align_o = confirm && (!lk_q || (cur_q != mcode));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pv_q  <= 1'b0;
         pc_q  <= '0;
         lk_q  <= 1'b0;
         cur_q <= '0;
      end else if (meas) begin
         if (!mhit) begin
            pv_q <= 1'b0;
            lk_q <= 1'b0;
         end else begin
            pv_q <= 1'b1;
            pc_q <= mcode;
            if (align_o) begin
               lk_q  <= 1'b1;
               cur_q <= mcode;
            end
         end
      end
   end

   assign hit_o    = mhit;
   assign locked_o = lk_q;
   assign code_o   = cur_q;
endmodule

// File: rtl/crd_phase.sv
module crd_phase
   import crd_pkg::*;
#(
   parameter int unsigned BASE_RATIO     = 128,
   parameter int unsigned BITS_PER_FRAME = 64,
   parameter int unsigned DRIFT_LIMIT    = 8
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        edge_i,
   input  logic        bit_rise_i,
   input  logic        locked_i,
   input  logic        hit_i,
   input  logic        align_i,
   input  ratio_code_t code_i,
   output logic        resync_o
);
   localparam int unsigned MAX_RATIO = ratio_of(BASE_RATIO, CODE_W'(NUM_RATIOS - 1));
   localparam int unsigned LW        = $clog2(MAX_RATIO);
   localparam int unsigned BW        = $clog2(BITS_PER_FRAME + 1);

   logic [LW-1:0] lcnt_q, last;
   logic [BW-1:0] bcnt_q, b_now, err;
   logic          bnd, resync_now, realign, resync_q;

   assign last       = LW'(ratio_of(BASE_RATIO, code_i) - 1);
   assign bnd        = (lcnt_q == '0);
   assign b_now      = bnd ? '0 : bcnt_q;
   assign err        = (b_now <= BW'(BITS_PER_FRAME / 2)) ? b_now : BW'(BITS_PER_FRAME) - b_now;
   assign resync_now = edge_i && locked_i && hit_i && !align_i && (err > BW'(DRIFT_LIMIT));
   assign realign    = align_i || resync_now;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lcnt_q   <= '0;
         bcnt_q   <= '0;
         resync_q <= 1'b0;
      end else begin
         resync_q <= resync_now;
         if (realign)             lcnt_q <= LW'(1);
         else if (lcnt_q == last) lcnt_q <= '0;
         else                     lcnt_q <= lcnt_q + 1'b1;
         if (realign || bnd)
            bcnt_q <= bit_rise_i ? BW'(1) : '0;
         else if (bit_rise_i && (bcnt_q != BW'(BITS_PER_FRAME)))
            bcnt_q <= bcnt_q + 1'b1;
      end
   end

   assign resync_o = resync_q;
endmodule

// File: rtl/mclk_ratio_monitor.sv
module mclk_ratio_monitor
   import crd_pkg::*;
#(
   parameter int unsigned BASE_RATIO     = 128,
   parameter int unsigned TOL_DIV        = 50,
   parameter int unsigned BITS_PER_FRAME = 64,
   parameter int unsigned DRIFT_LIMIT    = 8,
   parameter int unsigned RELEASE_DLY    = 4,
   parameter int unsigned MUTE_FRAMES    = 32,
   parameter int unsigned MUTE_RATIO     = 256,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic       mclk_i,
   input  logic       rst_ni,
   input  logic       frame_clk_i,
   input  logic       bit_clk_i,
   output logic [2:0] ratio_code_o,
   output logic       locked_o,
   output logic       resync_o,
   output logic       mute_o
);
   localparam int unsigned MAX_RATIO   = ratio_of(BASE_RATIO, CODE_W'(NUM_RATIOS - 1));
   localparam int unsigned PERIOD_SAT  = 2 * MAX_RATIO;
   localparam int unsigned MUTE_CYCLES = MUTE_FRAMES * MUTE_RATIO;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RELEASE_DLY < 1) begin : g_chk_rel
      $error("RELEASE_DLY must be at least 1");
   end
   if (2 * DRIFT_LIMIT >= BITS_PER_FRAME) begin : g_chk_drift
      $error("DRIFT_LIMIT must be below half a frame");
   end
   if ((BASE_RATIO % BITS_PER_FRAME) != 0) begin : g_chk_base
      $error("BASE_RATIO must be a multiple of BITS_PER_FRAME");
   end
   if (TOL_DIV < 8) begin : g_chk_tol
      $error("TOL_DIV too small: ratio windows would overlap");
   end

   logic int_rst_n;

   crd_startup #(
      .RELEASE_DLY (RELEASE_DLY),
      .MUTE_CYCLES (MUTE_CYCLES)
   ) u_startup (
      .clk_i      (mclk_i),
      .rst_ni     (rst_ni),
      .int_rst_no (int_rst_n),
      .mute_o     (mute_o)
   );

   logic [1:0] sync_q;
   crd_sync #(
      .STAGES (SYNC_STAGES),
      .W      (2)
   ) u_sync (
      .clk_i  (mclk_i),
      .rst_ni (int_rst_n),
      .d_i    ({frame_clk_i, bit_clk_i}),
      .q_o    (sync_q)
   );

   logic frm_prev_q, bit_prev_q, frm_edge, bit_rise;
   always_ff @(posedge mclk_i or negedge int_rst_n) begin
      if (!int_rst_n) begin
         frm_prev_q <= 1'b0;
         bit_prev_q <= 1'b0;
      end else begin
         frm_prev_q <= sync_q[1];
         bit_prev_q <= sync_q[0];
      end
   end
   assign frm_edge = sync_q[1] && !frm_prev_q;
   assign bit_rise = sync_q[0] && !bit_prev_q;

   logic        hit, align, locked;
   ratio_code_t code;

   crd_classify #(
      .BASE_RATIO (BASE_RATIO),
      .TOL_DIV    (TOL_DIV),
      .PERIOD_SAT (PERIOD_SAT)
   ) u_classify (
      .clk_i    (mclk_i),
      .rst_ni   (int_rst_n),
      .edge_i   (frm_edge),
      .hit_o    (hit),
      .align_o  (align),
      .locked_o (locked),
      .code_o   (code)
   );

   crd_phase #(
      .BASE_RATIO     (BASE_RATIO),
      .BITS_PER_FRAME (BITS_PER_FRAME),
      .DRIFT_LIMIT    (DRIFT_LIMIT)
   ) u_phase (
      .clk_i      (mclk_i),
      .rst_ni     (int_rst_n),
      .edge_i     (frm_edge),
      .bit_rise_i (bit_rise),
      .locked_i   (locked),
      .hit_i      (hit),
      .align_i    (align),
      .code_i     (code),
      .resync_o   (resync_o)
   );

   assign ratio_code_o = code;
   assign locked_o     = locked;
endmodule

// File: rtl/mclk_ratio_monitor_chk.sv
module mclk_ratio_monitor_chk #(
   parameter int unsigned MUTE_CYCLES = 8192,
   parameter int unsigned NUM_CODES   = 6
) (
   input logic       clk_i,
   input logic       rst_ni,
   input logic [2:0] ratio_code_i,
   input logic       locked_i,
   input logic       resync_i,
   input logic       mute_i
);
   int unsigned since_rst_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         since_rst_q <= 0;
      else if (since_rst_q != 32'hFFFF_FFFF) since_rst_q <= since_rst_q + 1;
   end

   // R1: reset forces the output state
   always @(posedge clk_i) begin
      if (!rst_ni) begin
         p_reset_state_r1: assert (mute_i && !locked_i && !resync_i && ratio_code_i == 3'd0)
            else $error("reset state wrong");
      end
   end

   p_mute_min_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mute_i |-> (since_rst_q >= MUTE_CYCLES));

   p_mute_final_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !mute_i |=> !mute_i);

   p_code_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ratio_code_i < 3'(NUM_CODES));

   p_code_change_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(ratio_code_i) |-> locked_i);

   p_resync_locked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resync_i |-> locked_i);

   p_resync_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      resync_i |=> !resync_i);
endmodule

bind mclk_ratio_monitor mclk_ratio_monitor_chk #(
   .MUTE_CYCLES (MUTE_FRAMES * MUTE_RATIO),
   .NUM_CODES   (crd_pkg::NUM_RATIOS)
) u_chk (
   .clk_i        (mclk_i),
   .rst_ni       (rst_ni),
   .ratio_code_i (ratio_code_o),
   .locked_i     (locked_o),
   .resync_i     (resync_o),
   .mute_i       (mute_o)
);

// File: tb/sim_mclk_ratio_monitor.sv
module sim_mclk_ratio_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int MUTE_TOTAL = 4 + 32 * 256;

   logic       mclk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       frm = 1'b0;
   logic       bclk = 1'b0;
   logic [2:0] code;
   logic       locked, resync, mute;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD / 2) mclk = ~mclk;

   mclk_ratio_monitor u0 (
      .mclk_i       (mclk),
      .rst_ni       (rst_ni),
      .frame_clk_i  (frm),
      .bit_clk_i    (bclk),
      .ratio_code_o (code),
      .locked_o     (locked),
      .resync_o     (resync),
      .mute_o       (mute)
   );

   // resync pulse counter and pulse-width tracker
   int  rs_cnt = 0;
   int  rs_run = 0;
   int  rs_max = 0;
   always @(negedge mclk) begin
      if (resync) begin
         rs_cnt = rs_cnt + 1;
         rs_run = rs_run + 1;
         if (rs_run > rs_max) rs_max = rs_run;
      end else begin
         rs_run = 0;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // scoreboard
   typedef struct {
      string    tag;
      logic [2:0] exp_code;
      logic     exp_lock;
      bit       use_code;
   } exp_t;

   exp_t q[$];
   event chk_ev;

   task automatic expect_state(input string tag, input logic [2:0] c, input logic l, input bit use_c);
      exp_t e;
      e.tag = tag; e.exp_code = c; e.exp_lock = l; e.use_code = use_c;
      q.push_back(e);
      ->chk_ev;
      @(negedge mclk);
   endtask

   initial begin
      forever begin
         @(chk_ev);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check({e.tag, " locked"}, int'(locked), int'(e.exp_lock));
            if (e.use_code) check({e.tag, " code"}, int'(code), int'(e.exp_code));
         end
      end
   end

   // frame driver: frame clock high for the first half, bit clock of period div
   task automatic run_frames(input int period, input int div, input int n);
      for (int f = 0; f < n; f++) begin
         for (int i = 0; i < period; i++) begin
            @(negedge mclk);
            frm  = (i < period / 2);
            bclk = ((i % div) < (div / 2));
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge mclk);
         frm  = 1'b0;
         bclk = 1'b0;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5) @(negedge mclk);
      // R1 reset state
      check("R1 mute", int'(mute), 1);
      check("R1 locked", int'(locked), 0);
      check("R1 resync", int'(resync), 0);
      check("R1 code", int'(code), 0);
      rst_ni = 1'b1;

      // R2 mute interval with the frame clock idle
      idle(MUTE_TOTAL - 6);
      check("R2 mute before end", int'(mute), 1);
      idle(12);
      check("R2 mute after end", int'(mute), 0);

      // R4 no lock after a single measurement
      run_frames(256, 4, 2);
      expect_state("R4 one measurement", 3'd0, 1'b0, 1'b0);
      run_frames(256, 4, 6);
      expect_state("R4 lock 256", 3'd2, 1'b1, 1'b1);

      // R3 every ratio, then tolerance edges
      run_frames(128, 2, 6);  expect_state("R3 ratio 128", 3'd0, 1'b1, 1'b1);
      run_frames(192, 3, 6);  expect_state("R3 ratio 192", 3'd1, 1'b1, 1'b1);
      run_frames(256, 4, 6);  expect_state("R3 ratio 256", 3'd2, 1'b1, 1'b1);
      run_frames(384, 6, 6);  expect_state("R3 ratio 384", 3'd3, 1'b1, 1'b1);
      run_frames(512, 8, 6);  expect_state("R3 ratio 512", 3'd4, 1'b1, 1'b1);
      run_frames(768, 12, 6); expect_state("R3 ratio 768", 3'd5, 1'b1, 1'b1);
      run_frames(130, 2, 6);  expect_state("R3 tol 130", 3'd0, 1'b1, 1'b1);
      run_frames(753, 12, 6); expect_state("R3 tol 753", 3'd5, 1'b1, 1'b1);

      // R6 just outside the 256 window: unlocked, code kept
      run_frames(262, 4, 3);
      expect_state("R6 no match 262", 3'd5, 1'b0, 1'b1);

      // R9 no resync while unlocked
      rs_cnt = 0;
      run_frames(300, 4, 3);
      check("R9 unlocked resync count", rs_cnt, 0);
      expect_state("R6 no match 300", 3'd5, 1'b0, 1'b1);

      // R9 exact period, no resync
      run_frames(256, 4, 6);
      expect_state("R5 relock 256", 3'd2, 1'b1, 1'b1);
      rs_cnt = 0;
      run_frames(256, 4, 10);
      check("R9 exact period resync count", rs_cnt, 0);

      // R5 single differing measurement ignored
      run_frames(384, 6, 1);
      run_frames(256, 4, 3);
      expect_state("R5 single 384", 3'd2, 1'b1, 1'b1);
      run_frames(384, 6, 2);
      expect_state("R5 one 384 measured", 3'd2, 1'b1, 1'b1);
      run_frames(384, 6, 1);
      expect_state("R5 two 384 measured", 3'd3, 1'b1, 1'b1);

      // R8 steady drift forces resync, R10 pulse width
      run_frames(256, 4, 6);
      expect_state("R8 lock before drift", 3'd2, 1'b1, 1'b1);
      rs_cnt = 0;
      rs_max = 0;
      run_frames(261, 4, 20);
      check("R8 resync seen", int'(rs_cnt > 0), 1);
      check("R10 pulse width", rs_max, 1);
      expect_state("R8 still locked", 3'd2, 1'b1, 1'b1);

      // R7 frame clock stops
      idle(2000);
      expect_state("R7 frame lost", 3'd2, 1'b0, 1'b1);
      check("R2 mute stays off", int'(mute), 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule